// File: doc/BRIEF.md
# Staged Sync and Calibration Trigger

This block is a two-bit control register whose written values are staged and only take effect on an update strobe. Each write lands in a shadow copy, and the update strobe copies the shadow into an active copy. One active bit controls the distribution sync and the other controls the system-clock PLL calibration. All outputs are derived from the active copy.

While the active sync bit is set, the distribution stall output is high. Clearing the bit and committing the change releases the stall and fires a one-cycle sync pulse.

Committing a 0-to-1 change of the calibrate bit while the PLL is enabled fires a one-cycle calibration start pulse. That pulse also enters a busy state. For the whole busy state the system-clock enable is low, and the busy state ends when the calibration-done input is seen. To recalibrate when the bit is already 1, software must write 0, strobe update, write 1 and strobe update again.

Top module: `sync_cal_stage`

## Requirements
- R1: A write (`wr_en`) changes only the shadow copy. With `upd` held low, none of the outputs changes, whatever is written.
- R2: `dist_stall` follows the active sync bit. It rises in the cycle after the clock edge at which `upd` commits a shadow sync value of 1.
- R3: `sync_pulse` is high for exactly one cycle, in the same cycle that `dist_stall` falls. It fires only when an update changes the active sync bit from 1 to 0, and never on an update that leaves the bit at 1.
- R4: When an update changes the active calibrate bit from 0 to 1 with `pll_en` high in that cycle, `cal_start` is high for exactly the following cycle.
- R5: The following commits start no calibration: a commit made while `pll_en` is low, and a commit that writes 1 over an active 1. In both cases the active bit is still 1, so a new start needs a commit of 0 and then a commit of 1.
- R6: `cal_busy` rises together with `cal_start`, and `sysclk_en` is low for as long as `cal_busy` is high.
- R7: `cal_busy` clears after the first clock edge at which `cal_done` is high. `cal_done` has no effect while the block is idle.
- R8: A 0-to-1 commit of the calibrate bit made while `cal_busy` is high is dropped: no `cal_start` is produced.
- R9: After reset both shadow and active bits are 0. `dist_stall`, `sync_pulse`, `cal_start` and `cal_busy` are low, and `sysclk_en` is high.
- R10: When `wr_en` and `upd` are high in the same cycle, the update commits the shadow value held before that write. The new value takes effect only on a later update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write the shadow bits |
| wr_sync | input | 1 | Sync value to write |
| wr_cal | input | 1 | Calibrate value to write |
| upd | input | 1 | Update strobe: copy shadow to active |
| pll_en | input | 1 | PLL enabled; gates calibration start |
| cal_done | input | 1 | Calibration finished |
| dist_stall | output | 1 | Distribution held stalled |
| sync_pulse | output | 1 | One-cycle distribution sync |
| cal_start | output | 1 | One-cycle calibration start |
| cal_busy | output | 1 | Calibration in progress |
| sysclk_en | output | 1 | System clock enable |

## Verification
A write takes one edge to reach the shadow copy. Every other result (stall level, sync pulse, calibration start, busy set and busy clear) appears right after the single edge at which `upd` or `cal_done` is sampled. Pulses drop again after the next edge. The bench drives inputs on the falling edge and samples one falling edge after the stimulus. It checks that each pulse has dropped one cycle later, and it checks the held outputs again after idle gaps to confirm that nothing moves without a strobe.

// File: rtl/sync_cal_stage.sv
module sync_cal_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_sync,
  input  logic wr_cal,
  input  logic upd,
  input  logic pll_en,
  input  logic cal_done,
  output logic dist_stall,
  output logic sync_pulse,
  output logic cal_start,
  output logic cal_busy,
  output logic sysclk_en
);

  logic shd_sync, shd_cal;
  logic act_sync, act_cal;
  logic busy_q, sync_q, start_q;

  wire sync_fall = upd & act_sync & ~shd_sync;
  wire cal_rise  = upd & ~act_cal & shd_cal;
  wire cal_go    = cal_rise & pll_en & ~busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd_sync <= 1'b0;
      shd_cal  <= 1'b0;
    end else if (wr_en) begin
      shd_sync <= wr_sync;
      shd_cal  <= wr_cal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_sync <= 1'b0;
      act_cal  <= 1'b0;
    end else if (upd) begin
      act_sync <= shd_sync;
      act_cal  <= shd_cal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      start_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      sync_q  <= sync_fall;
      start_q <= cal_go;
      if (cal_go)
        busy_q <= 1'b1;
      else if (cal_done)
        busy_q <= 1'b0;
    end
  end

  assign dist_stall = act_sync;
  assign sync_pulse = sync_q;
  assign cal_start  = start_q;
  assign cal_busy   = busy_q;
  assign sysclk_en  = ~busy_q;

  p_stall_needs_upd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dist_stall) |-> $past(upd));

  p_hold_without_upd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(upd) |-> $stable(dist_stall));

  p_sync_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> $fell(dist_stall));

  p_sync_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> !sync_pulse);

  p_cal_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> ($past(pll_en) && $past(upd)));

  p_cal_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start);

  p_busy_with_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> (cal_busy && !sysclk_en));

  p_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && cal_done) |=> !cal_busy);

  p_no_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && !cal_done) |=> !cal_start);

endmodule

// File: tb/test_sync_cal_stage.sv
module test_sync_cal_stage;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sync = 1'b0, wr_cal = 1'b0, upd = 1'b0;
  logic pll_en = 1'b1, cal_done = 1'b0;
  logic dist_stall, sync_pulse, cal_start, cal_busy, sysclk_en;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  sync_cal_stage i_sync_cal_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sync(wr_sync), .wr_cal(wr_cal),
    .upd(upd), .pll_en(pll_en), .cal_done(cal_done),
    .dist_stall(dist_stall), .sync_pulse(sync_pulse), .cal_start(cal_start),
    .cal_busy(cal_busy), .sysclk_en(sysclk_en));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wr(input logic s, input logic c);
    wr_en = 1'b1; wr_sync = s; wr_cal = c; step(); wr_en = 1'b0;
  endtask

  task automatic strobe(); upd = 1'b1; step(); upd = 1'b0; endtask

  task automatic finish_cal();
    cal_done = 1'b1; step(); cal_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9", "dist_stall", dist_stall, 1'b0);
    chk("R9", "sync_pulse", sync_pulse, 1'b0);
    chk("R9", "cal_start", cal_start, 1'b0);
    chk("R9", "cal_busy", cal_busy, 1'b0);
    chk("R9", "sysclk_en", sysclk_en, 1'b1);
  endtask

  task automatic t_shadow();
    wr(1'b1, 1'b1);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R1", "dist_stall idle", dist_stall, 1'b0);
      chk("R1", "cal_busy idle", cal_busy, 1'b0);
    end
    wr(1'b0, 1'b0);
  endtask

  task automatic t_sync();
    wr(1'b1, 1'b0);
    strobe();
    chk("R2", "stall after commit", dist_stall, 1'b1);
    chk("R3", "no pulse on rise", sync_pulse, 1'b0);
    strobe();
    chk("R3", "no pulse on 1->1", sync_pulse, 1'b0);
    wr(1'b0, 1'b0);
    step();
    chk("R1", "stall held before upd", dist_stall, 1'b1);
    strobe();
    chk("R3", "stall falls", dist_stall, 1'b0);
    chk("R3", "sync pulse", sync_pulse, 1'b1);
    step();
    chk("R3", "pulse one cycle", sync_pulse, 1'b0);
  endtask

  task automatic t_cal();
    pll_en = 1'b1;
    wr(1'b0, 1'b1);
    strobe();
    chk("R4", "cal_start", cal_start, 1'b1);
    chk("R6", "busy", cal_busy, 1'b1);
    chk("R6", "sysclk_en low", sysclk_en, 1'b0);
    step();
    chk("R4", "start one cycle", cal_start, 1'b0);
    repeat (5) step();
    chk("R6", "still busy", cal_busy, 1'b1);
    chk("R6", "sysclk_en still low", sysclk_en, 1'b0);
    finish_cal();
    chk("R7", "busy cleared", cal_busy, 1'b0);
    chk("R7", "sysclk_en back", sysclk_en, 1'b1);
  endtask

  task automatic t_recal();
    wr(1'b0, 1'b1);
    strobe();
    chk("R5", "no start 1 over 1", cal_start, 1'b0);
    wr(1'b0, 1'b0); strobe();
    wr(1'b0, 1'b1); strobe();
    chk("R5", "start after 0 then 1", cal_start, 1'b1);
    finish_cal();
  endtask

  task automatic t_pll_off();
    wr(1'b0, 1'b0); strobe();
    pll_en = 1'b0;
    wr(1'b0, 1'b1); strobe();
    chk("R5", "no start pll off", cal_start, 1'b0);
    chk("R5", "no busy pll off", cal_busy, 1'b0);
    pll_en = 1'b1;
    strobe();
    chk("R5", "no start after pll on", cal_start, 1'b0);
    wr(1'b0, 1'b0); strobe();
  endtask

  task automatic t_busy_rise();
    wr(1'b0, 1'b1); strobe();
    chk("R4", "start for busy test", cal_start, 1'b1);
    wr(1'b0, 1'b0); strobe();
    wr(1'b0, 1'b1); strobe();
    chk("R8", "rise while busy dropped", cal_start, 1'b0);
    chk("R8", "still busy", cal_busy, 1'b1);
    finish_cal();
    finish_cal();
    chk("R7", "done while idle", cal_busy, 1'b0);
    chk("R7", "sysclk_en idle", sysclk_en, 1'b1);
    wr(1'b0, 1'b0); strobe();
  endtask

  task automatic t_same_cycle();
    wr_en = 1'b1; wr_sync = 1'b1; wr_cal = 1'b0; upd = 1'b1;
    step();
    wr_en = 1'b0; upd = 1'b0;
    chk("R10", "old shadow committed", dist_stall, 1'b0);
    strobe();
    chk("R10", "new value on next upd", dist_stall, 1'b1);
    wr(1'b0, 1'b0); strobe();
    chk("R3", "cleanup pulse", sync_pulse, 1'b1);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_shadow();
    t_sync();
    t_cal();
    t_recal();
    t_pll_off();
    t_busy_rise();
    t_same_cycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule